// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block turns a logical address, given as a segment selector and a 32-bit offset, into a linear address that a later paging stage can consume. It keeps a small table of segment descriptors, one per selector. Each descriptor holds a base, a size and a present flag. A request looks up the descriptor for its selector. If the descriptor is present and the offset lies below the segment size, the block adds the base to the offset and returns the sum. Otherwise it returns a fault with a code that gives the reason.

Descriptors are written through a write port that acts only when the supervisor qualifier is set at the same time. The size field is one bit wider than the offset, so a segment can span the full 4 GB space. A descriptor with base 0 and size 2^32 passes every offset through unchanged, which turns segmentation off in effect. The result is registered and appears one clock after the request.

Top module: `seg_xlate`

## Requirements
- R1: After a synchronous active-low reset, rsp_valid, rsp_fault, rsp_kind and rsp_addr are all zero, and every descriptor is marked not present.
- R2: When wr_en and wr_super are both 1 at a clock edge, the descriptor at wr_sel takes wr_base, wr_size and wr_present. Requests made in later cycles see the new contents.
- R3: A write with wr_en=1 and wr_super=0 leaves the table unchanged.
- R4: rsp_valid is 1 in exactly the cycle after a cycle with req_valid=1, and 0 otherwise. When rsp_valid is 0, rsp_addr, rsp_fault and rsp_kind are 0.
- R5: A request to a descriptor that is not present returns rsp_fault=1, rsp_kind=2'b01 and rsp_addr=0. This code takes priority over the range check.
- R6: A request to a present descriptor whose offset is greater than or equal to its size returns rsp_fault=1, rsp_kind=2'b10 and rsp_addr=0.
- R7: A request to a present descriptor whose offset is below its size returns rsp_fault=0, rsp_kind=2'b00 and rsp_addr = (base + offset) mod 2^32.
- R8: wr_size is 33 bits wide. A descriptor with base 0 and size 2^32 maps every offset, including 0xFFFFFFFF, to itself without a fault.
- R9: When a supervisor write and a request address the same selector in the same cycle, the request is translated with the descriptor contents from before the write.
- R10: A present descriptor with size 0 faults (code 2'b10) for every offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_super | input | 1 | Supervisor qualifier; a write acts only when this is 1 |
| wr_sel | input | 4 | Selector of the descriptor to write |
| wr_base | input | 32 | New segment base |
| wr_size | input | 33 | New segment size in bytes (0 to 2^32) |
| wr_present | input | 1 | New present flag |
| req_valid | input | 1 | Translation request strobe |
| req_sel | input | 4 | Request selector |
| req_offset | input | 32 | Request offset within the segment |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_addr | output | 32 | Linear address; 0 on a fault |
| rsp_fault | output | 1 | Translation refused |
| rsp_kind | output | 2 | Fault code: 00 none, 01 not present, 10 out of range |

## Verification
A descriptor write and a translation request can land on the same selector in one clock. The bench drives both at once and expects the result built from the old descriptor. It then sends a request in the next cycle and expects the result built from the new descriptor. A second overlap of checks comes from a descriptor that is both not present and too small for the offset. Both fault conditions hold for that request, and only the not-present code may be reported.

// File: rtl/seg_xlate_pkg.sv
// Package: shared types for the segment translator.
// Assumes: fault codes are visible on the rsp_kind port and may not change.
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_ABSENT = 2'b01,
        FLT_RANGE  = 2'b10
    } flt_e;

endpackage

// File: rtl/seg_table.sv
// Module: seg_table
// Holds one descriptor (base, size, present) per selector and reads it
// out combinationally. Writes are registered, so a read in the cycle of a
// write returns the old contents.
// Assumes: the caller has already applied the supervisor qualifier to we.
module seg_table #(
    parameter int SEL_W = 4,
    parameter int OFS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  logic [OFS_W-1:0] wbase,
    input  logic [OFS_W:0]   wsize,
    input  logic             wpresent,
    input  logic [SEL_W-1:0] rsel,
    output logic [OFS_W-1:0] rbase,
    output logic [OFS_W:0]   rsize,
    output logic             rpresent
);
    localparam int N_ENT = 1 << SEL_W;

    logic [OFS_W-1:0] base_q    [N_ENT];
    logic [OFS_W:0]   size_q    [N_ENT];
    logic             present_q [N_ENT];

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        // Clear the descriptor on reset, else load it when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[i]    <= '0;
                size_q[i]    <= '0;
                present_q[i] <= 1'b0;
            end else if (we && (wsel == SEL_W'(i))) begin
                base_q[i]    <= wbase;
                size_q[i]    <= wsize;
                present_q[i] <= wpresent;
            end
        end
    end

    // Select the descriptor for the request.
    always_comb begin
        rbase    = base_q[rsel];
        rsize    = size_q[rsel];
        rpresent = present_q[rsel];
    end
endmodule

// File: rtl/seg_check.sv
// Module: seg_check
// Decides whether an offset is legal for one descriptor and forms the
// linear address. The present check has priority over the range check.
// Assumes: size is one bit wider than the offset, so 2^32 can be stored.
module seg_check #(
    parameter int OFS_W = 32
) (
    input  logic                 present,
    input  logic [OFS_W-1:0]     base,
    input  logic [OFS_W:0]       size,
    input  logic [OFS_W-1:0]     offset,
    output seg_xlate_pkg::flt_e  kind,
    output logic [OFS_W-1:0]     lin
);
    import seg_xlate_pkg::*;

    // Classify the request and add the base, wrapping at the offset width.
    always_comb begin
        lin = base + offset;
        if (!present) begin
            kind = FLT_ABSENT;
        end else if ({1'b0, offset} >= size) begin
            kind = FLT_RANGE;
        end else begin
            kind = FLT_NONE;
        end
    end
endmodule

// File: rtl/seg_out_reg.sv
// Module: seg_out_reg
// Registers the translation result. It zeroes the address on a fault and
// zeroes every field in a cycle without a request.
// Assumes: kind and lin are valid whenever in_valid is set.
module seg_out_reg #(
    parameter int OFS_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  seg_xlate_pkg::flt_e kind,
    input  logic [OFS_W-1:0]    lin,
    output logic                rsp_valid,
    output logic [OFS_W-1:0]    rsp_addr,
    output logic                rsp_fault,
    output logic [1:0]          rsp_kind
);
    import seg_xlate_pkg::*;

    // Capture one result per request; stay quiet otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_fault <= 1'b0;
            rsp_kind  <= 2'b00;
        end else begin
            rsp_valid <= 1'b1;
            rsp_fault <= (kind != FLT_NONE);
            rsp_kind  <= kind;
            rsp_addr  <= (kind == FLT_NONE) ? lin : '0;
        end
    end
endmodule

// File: rtl/seg_xlate.sv
// Module: seg_xlate (top)
// Translates selector plus offset into a linear address through a
// descriptor table, one registered result per request.
// Assumes: a single supervisor qualifier guards every table write.
module seg_xlate #(
    parameter int SEL_W = 4,
    parameter int OFS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_super,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [OFS_W-1:0] wr_base,
    input  logic [OFS_W:0]   wr_size,
    input  logic             wr_present,
    input  logic             req_valid,
    input  logic [SEL_W-1:0] req_sel,
    input  logic [OFS_W-1:0] req_offset,
    output logic             rsp_valid,
    output logic [OFS_W-1:0] rsp_addr,
    output logic             rsp_fault,
    output logic [1:0]       rsp_kind
);
    import seg_xlate_pkg::*;

    logic             tbl_we;
    logic [OFS_W-1:0] d_base;
    logic [OFS_W:0]   d_size;
    logic             d_present;
    flt_e             chk_kind;
    logic [OFS_W-1:0] chk_lin;

    // Only supervisor writes reach the table.
    assign tbl_we = wr_en & wr_super;

    seg_table #(.SEL_W(SEL_W), .OFS_W(OFS_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (tbl_we),
        .wsel     (wr_sel),
        .wbase    (wr_base),
        .wsize    (wr_size),
        .wpresent (wr_present),
        .rsel     (req_sel),
        .rbase    (d_base),
        .rsize    (d_size),
        .rpresent (d_present)
    );

    seg_check #(.OFS_W(OFS_W)) u_check (
        .present (d_present),
        .base    (d_base),
        .size    (d_size),
        .offset  (req_offset),
        .kind    (chk_kind),
        .lin     (chk_lin)
    );

    seg_out_reg #(.OFS_W(OFS_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .kind      (chk_kind),
        .lin       (chk_lin),
        .rsp_valid (rsp_valid),
        .rsp_addr  (rsp_addr),
        .rsp_fault (rsp_fault),
        .rsp_kind  (rsp_kind)
    );
endmodule

// File: rtl/seg_xlate_chk.sv
// Module: seg_xlate_chk
// Protocol checks on the port behaviour of seg_xlate, attached by bind.
// Assumes: default parameter widths.
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        rsp_valid,
    input logic [31:0] rsp_addr,
    input logic        rsp_fault,
    input logic [1:0]  rsp_kind
);
    // R4: a request yields a result in the next cycle.
    a_r4_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R4: no result without a request in the previous cycle.
    a_r4_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4: an idle output carries no address or fault.
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_addr == 32'd0 && !rsp_fault && rsp_kind == 2'b00));

    // R5/R6: a refused translation never exposes an address.
    a_r6_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_addr == 32'd0);

    // R7: the fault flag and the fault code agree, and 2'b11 never occurs.
    a_r7_kind_matches_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_fault == (rsp_kind != 2'b00)) && rsp_kind != 2'b11));

    // R1: the first cycle after reset shows no result.
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rsp_valid);
endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .rsp_fault (rsp_fault),
    .rsp_kind  (rsp_kind)
);

// File: tb/test_seg_xlate.sv
// Bench: scoreboard for seg_xlate. Driver tasks push expected results and
// a monitor pops and compares them at each falling edge.
module test_seg_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_super = 1'b0, wr_present = 1'b0;
    logic [3:0]  wr_sel = '0, req_sel = '0;
    logic [31:0] wr_base = '0, req_offset = '0;
    logic [32:0] wr_size = '0;
    logic        req_valid = 1'b0;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_addr;
    logic [1:0]  rsp_kind;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // Reference descriptor table kept by the bench
    logic [31:0] m_base [16];
    logic [32:0] m_size [16];
    logic        m_pres [16];

    logic [31:0] q_addr [$];
    logic [1:0]  q_kind [$];
    string       q_tag  [$];

    always #10 clk = ~clk;  // 50 MHz

    seg_xlate i_seg_xlate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_super(wr_super),
        .wr_sel(wr_sel), .wr_base(wr_base), .wr_size(wr_size),
        .wr_present(wr_present), .req_valid(req_valid), .req_sel(req_sel),
        .req_offset(req_offset), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_fault(rsp_fault), .rsp_kind(rsp_kind)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Push the expected result for a request under the current model.
    task automatic expect_req(input logic [3:0] sel, input logic [31:0] off, input string tag);
        if (!m_pres[sel]) begin
            q_addr.push_back(32'd0); q_kind.push_back(2'b01);
        end else if ({1'b0, off} >= m_size[sel]) begin
            q_addr.push_back(32'd0); q_kind.push_back(2'b10);
        end else begin
            q_addr.push_back(m_base[sel] + off); q_kind.push_back(2'b00);
        end
        q_tag.push_back(tag);
    endtask

    // Drive one cycle with an optional write and an optional request.
    task automatic cyc(input bit do_wr, input bit sup, input logic [3:0] ws,
                       input logic [31:0] wb, input logic [32:0] wz, input bit wp,
                       input bit do_rq, input logic [3:0] rs, input logic [31:0] ro,
                       input string tag);
        if (do_rq) expect_req(rs, ro, tag);
        if (do_wr && sup) begin
            m_base[ws] = wb; m_size[ws] = wz; m_pres[ws] = wp;
        end
        wr_en = do_wr; wr_super = sup; wr_sel = ws; wr_base = wb;
        wr_size = wz; wr_present = wp;
        req_valid = do_rq; req_sel = rs; req_offset = ro;
        @(negedge clk);
        wr_en = 1'b0; wr_super = 1'b0; req_valid = 1'b0;
    endtask

    task automatic wr(input bit sup, input logic [3:0] s, input logic [31:0] b,
                      input logic [32:0] z, input bit p);
        cyc(1'b1, sup, s, b, z, p, 1'b0, 4'd0, 32'd0, "");
    endtask

    task automatic rq(input logic [3:0] s, input logic [31:0] o, input string tag);
        cyc(1'b0, 1'b0, 4'd0, 32'd0, 33'd0, 1'b0, 1'b1, s, o, tag);
    endtask

    // Monitor: pop and compare each result as it appears.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_tag.size() == 0) begin
                check("R4 unexpected rsp_valid", 32'd1, 32'd0);
            end else begin
                string t;
                logic [31:0] ea;
                logic [1:0] ek;
                t = q_tag.pop_front(); ea = q_addr.pop_front(); ek = q_kind.pop_front();
                check({t, " addr"}, rsp_addr, ea);
                check({t, " kind"}, {30'd0, rsp_kind}, {30'd0, ek});
                check({t, " fault"}, {31'd0, rsp_fault}, {31'd0, (ek != 2'b00)});
            end
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_base[i] = '0; m_size[i] = '0; m_pres[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs quiet after reset
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 rsp_addr", rsp_addr, 32'd0);
        check("R1 rsp_fault", {31'd0, rsp_fault}, 32'd0);
        rq(4'd3, 32'h0, "R1 entry absent after reset");
        rq(4'd15, 32'h10, "R5 absent entry");

        // R2, R7 in-range translation
        wr(1'b1, 4'd2, 32'h1000_0000, 33'h100, 1'b1);
        rq(4'd2, 32'h10, "R2 new descriptor used");
        rq(4'd2, 32'hFF, "R7 last legal offset");
        rq(4'd2, 32'h100, "R6 offset equals size");
        rq(4'd2, 32'hFFFF_FFFF, "R6 max offset");
        @(negedge clk);
        check("R4 idle after requests", {31'd0, rsp_valid}, 32'd0);

        // R3 non-supervisor write ignored
        wr(1'b0, 4'd2, 32'h0000_0005, 33'h1_0000_0000, 1'b0);
        rq(4'd2, 32'h10, "R3 user write ignored");

        // R5 priority: absent and too small at once
        wr(1'b1, 4'd4, 32'h4000, 33'h0, 1'b0);
        rq(4'd4, 32'h5, "R5 absent wins over range");

        // R8 flat segment
        wr(1'b1, 4'd7, 32'h0, 33'h1_0000_0000, 1'b1);
        rq(4'd7, 32'h0, "R8 flat zero");
        rq(4'd7, 32'hFFFF_FFFF, "R8 flat max");
        rq(4'd7, 32'h1234_5678, "R8 flat mid");

        // R10 zero-size segment
        wr(1'b1, 4'd9, 32'h8000, 33'h0, 1'b1);
        rq(4'd9, 32'h0, "R10 size zero");

        // R7 wrap around the address space
        wr(1'b1, 4'd10, 32'hFFFF_FF00, 33'h1000, 1'b1);
        rq(4'd10, 32'h200, "R7 sum wraps");

        // R9 write and request to the same selector in one cycle
        cyc(1'b1, 1'b1, 4'd2, 32'h2000_0000, 33'h100, 1'b1,
            1'b1, 4'd2, 32'h20, "R9 old contents in write cycle");
        rq(4'd2, 32'h20, "R9 new contents next cycle");
        repeat (2) @(negedge clk);
        check("R4 all results delivered", q_tag.size(), 32'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule